// File: doc/BRIEF.md
# Single-wire half-duplex UART transceiver

This block is a byte-level serial transceiver with two pin arrangements. In full-duplex operation it sends on its transmit pin and listens on a separate receive pin. When the half-duplex select input is high, one shared line carries both directions. The receive pin is then ignored and the receiver listens on the transmit pad input. The transmit output enable is dropped whenever no frame is being sent, so a pull-up or the far end can own the line.

A frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. Each bit lasts 16 oversample ticks. A free-running divider makes one tick every `CLKS_PER_TICK` clock cycles. A byte enters through a valid/ready port. The transmitter takes a byte only in a cycle where `tx_valid_i` and `tx_ready_o` are both high. The source must hold `tx_valid_i` and `tx_data_i` steady until that cycle. `tx_ready_o` stays low for the whole frame, and that is the only back-pressure.

Received bytes leave on a one-cycle strobe with no back-pressure. A consumer that misses the strobe loses the byte. The block does not arbitrate line conflicts. It raises a pulse when, during its own half-duplex transmission, the sampled line disagrees with the driven bit. If half-duplex is requested while an alternate pin function is active, the request is refused, a configuration-error output goes high, and the block keeps full-duplex behaviour.

Top module: `sw_uart`

## Requirements
- R1: After reset, with half-duplex off, the outputs read `tx_ready_o`=1, `txd_o`=1, `txd_oe_o`=1, `rx_valid_o`=0 and `cfg_err_o`=0.
- R2: An accepted byte leaves on `txd_o` as one start bit (0), eight data bits (bit 0 first) and one stop bit (1). Each bit lasts 16 ticks. Between frames the line is high.
- R3: A byte is taken in a cycle with `tx_valid_i` and `tx_ready_o` both high. From the next cycle `tx_ready_o` is low until the stop bit has ended.
- R4: In full-duplex mode a frame on `rxd_i` produces one single-cycle `rx_valid_o` pulse, with the byte (bit 0 received first) on `rx_data_o`.
- R5: A low level on the receive line that has returned high by the eighth tick after its falling edge is discarded. No byte is reported.
- R6: `rx_frame_err_o` comes with `rx_valid_o` and is 1 exactly when the stop bit is sampled low.
- R7: In half-duplex mode `rxd_i` has no effect, and frames are received from `txd_pad_i`.
- R8: In half-duplex mode `txd_oe_o` is 1 only while a frame is being sent. It is 0 when idle and while receiving.
- R9: In half-duplex mode the block never reports its own transmitted frame as a received byte.
- R10: In half-duplex mode, during transmission, a `tx_collide_o` pulse follows each bit whose line value at mid-bit differs from the driven value. No pulse comes when they agree.
- R11: When `half_dup_i` and `alt_func_i` are both 1, `cfg_err_o` is 1 and the block behaves as in full-duplex mode: `txd_oe_o` is 1 and reception uses `rxd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_dup_i | input | 1 | 1 requests single-wire half-duplex |
| alt_func_i | input | 1 | 1 when an alternate pin function is active; blocks half-duplex |
| cfg_err_o | output | 1 | Half-duplex request refused |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte on `tx_data_i` is valid |
| tx_ready_o | output | 1 | Transmitter can take a byte |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_frame_err_o | output | 1 | Stop bit was low, qualified by `rx_valid_o` |
| tx_collide_o | output | 1 | One-cycle pulse on a line/driver mismatch |
| txd_o | output | 1 | Transmit data to the pad |
| txd_oe_o | output | 1 | Transmit pad driver enable |
| txd_pad_i | input | 1 | Value seen on the transmit pad |
| rxd_i | input | 1 | Receive pin |

## Verification
`tx_ready_o` falls one cycle after acceptance. Transmit bit k occupies the window starting k×16 ticks after acceptance, and the first bit may be up to one tick short because the tick divider runs freely. The bench therefore samples `txd_o` and `txd_oe_o` at the middle of each bit window, where that slack cannot matter. A received byte appears about 9.5 bit times after the start edge (the stop-bit centre), plus two synchroniser cycles. A collision pulse follows the mid-bit tick of the bit concerned. The bench reads these results only after the whole frame and a one-bit gap have passed, using counters that an always block updates on each strobe.

// File: rtl/sw_uart_pkg.sv
package sw_uart_pkg;
  localparam int OSR       = 16;
  localparam int DATA_BITS = 8;
  localparam int PH_W      = $clog2(OSR);
  localparam int IDX_W     = $clog2(DATA_BITS + 2);
  localparam int BIDX_W    = $clog2(DATA_BITS);

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/sw_uart_tick.sv
module sw_uart_tick #(
  parameter int CLKS_PER_TICK = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = $clog2(CLKS_PER_TICK + 1);

  logic [CW-1:0] cnt;

  assign tick_o = (cnt == CW'(CLKS_PER_TICK - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sw_uart_sync.sv
module sw_uart_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '1;
      q_o  <= '1;
    end else begin
      meta <= d_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/sw_uart_tx.sv
module sw_uart_tx
  import sw_uart_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic                 valid_i,
  output logic                 ready_o,
  input  logic                 half_i,
  input  logic                 line_i,
  output logic                 txd_o,
  output logic                 collide_o
);
  logic                 busy;
  logic [DATA_BITS+1:0] frame;
  logic [PH_W-1:0]      ph;
  logic [IDX_W-1:0]     idx;

  assign ready_o = !busy;
  assign txd_o   = frame[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      frame     <= '1;
      ph        <= '0;
      idx       <= '0;
      collide_o <= 1'b0;
    end else begin
      collide_o <= 1'b0;
      if (!busy) begin
        if (valid_i) begin
          frame <= {1'b1, data_i, 1'b0};
          busy  <= 1'b1;
          ph    <= '0;
          idx   <= '0;
        end
      end else if (tick_i) begin
        if (ph == PH_W'(OSR/2 - 1) && half_i && (line_i != frame[0]))
          collide_o <= 1'b1;
        if (ph == PH_W'(OSR - 1)) begin
          ph    <= '0;
          frame <= {1'b1, frame[DATA_BITS+1:1]};
          if (idx == IDX_W'(DATA_BITS + 1)) busy <= 1'b0;
          else                              idx  <= idx + 1'b1;
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && ready_o |=> !ready_o); // R3
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> txd_o); // R2
  AST_COLLIDE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    collide_o |-> $past(half_i)); // R10
endmodule

// File: rtl/sw_uart_rx.sv
module sw_uart_rx
  import sw_uart_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 line_i,
  input  logic                 hold_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 ferr_o
);
  rx_state_e            state;
  logic [PH_W-1:0]      cnt;
  logic [BIDX_W-1:0]    bidx;
  logic [DATA_BITS-1:0] sh;
  logic                 prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      sh      <= '0;
      prev    <= 1'b1;
      data_o  <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (hold_i) begin
        state <= RX_IDLE;
        prev  <= 1'b1;
        cnt   <= '0;
      end else if (tick_i) begin
        prev <= line_i;
        case (state)
          RX_IDLE: begin
            if (prev && !line_i) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt == PH_W'(OSR/2 - 1)) begin
              cnt  <= '0;
              bidx <= '0;
              state <= line_i ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == PH_W'(OSR - 1)) begin
              cnt <= '0;
              sh  <= {line_i, sh[DATA_BITS-1:1]};
              if (bidx == BIDX_W'(DATA_BITS - 1)) state <= RX_STOP;
              else                                bidx  <= bidx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == PH_W'(OSR - 1)) begin
              cnt     <= '0;
              valid_o <= 1'b1;
              data_o  <= sh;
              ferr_o  <= !line_i;
              state   <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R4
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !valid_o); // R9
endmodule

// File: rtl/sw_uart.sv
module sw_uart
  import sw_uart_pkg::*;
#(
  parameter int CLKS_PER_TICK = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_dup_i,
  input  logic       alt_func_i,
  output logic       cfg_err_o,
  input  logic [7:0] tx_data_i,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  output logic       rx_frame_err_o,
  output logic       tx_collide_o,
  output logic       txd_o,
  output logic       txd_oe_o,
  input  logic       txd_pad_i,
  input  logic       rxd_i
);
  logic       tick;
  logic       half_eff;
  logic [1:0] pins_s;
  logic       rxd_s;
  logic       pad_s;
  logic       rx_line;
  logic       rx_hold;

  assign half_eff  = half_dup_i & ~alt_func_i;
  assign cfg_err_o = half_dup_i & alt_func_i;

  sw_uart_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_o(tick)
  );

  sw_uart_sync #(.W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({rxd_i, txd_pad_i}),
    .q_o  (pins_s)
  );

  assign rxd_s   = pins_s[1];
  assign pad_s   = pins_s[0];
  assign rx_line = half_eff ? pad_s : rxd_s;
  assign rx_hold = half_eff & ~tx_ready_o;

  sw_uart_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .data_i   (tx_data_i),
    .valid_i  (tx_valid_i),
    .ready_o  (tx_ready_o),
    .half_i   (half_eff),
    .line_i   (pad_s),
    .txd_o    (txd_o),
    .collide_o(tx_collide_o)
  );

  sw_uart_rx u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .line_i (rx_line),
    .hold_i (rx_hold),
    .data_o (rx_data_o),
    .valid_o(rx_valid_o),
    .ferr_o (rx_frame_err_o)
  );

  assign txd_oe_o = half_eff ? ~tx_ready_o : 1'b1;

  AST_HD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    half_eff && tx_ready_o |-> !txd_oe_o); // R8
  AST_CFG_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_o |-> txd_oe_o); // R11
  AST_NO_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    half_eff && !tx_ready_o |=> !rx_valid_o); // R9
endmodule

// File: tb/test_sw_uart.sv
module test_sw_uart;
  localparam int CPT = 4;
  localparam int BIT = 16 * CPT;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_dup = 1'b0;
  logic       alt_func = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       rx_drv = 1'b1;
  logic       pad_drv = 1'b1;
  logic       pad;
  logic       cfg_err, tx_ready, rx_valid, rx_ferr, collide, txd, txd_oe;
  logic [7:0] rx_data;

  int nchk = 0;
  int nerr = 0;
  int rx_cnt = 0;
  int col_cnt = 0;
  logic [7:0] rx_last = '0;
  logic       ferr_last = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign pad = (txd_oe && !txd) ? 1'b0 : pad_drv;

  sw_uart #(.CLKS_PER_TICK(CPT)) i_sw_uart (
    .clk(clk), .rst_n(rst_n), .half_dup_i(half_dup), .alt_func_i(alt_func),
    .cfg_err_o(cfg_err), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_frame_err_o(rx_ferr), .tx_collide_o(collide), .txd_o(txd),
    .txd_oe_o(txd_oe), .txd_pad_i(pad), .rxd_i(rx_drv)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        rx_cnt    <= rx_cnt + 1;
        rx_last   <= rx_data;
        ferr_last <= rx_ferr;
      end
      if (collide) col_cnt <= col_cnt + 1;
    end
  end

  function automatic bit frame_bit(input logic [7:0] b, input int k);
    if (k == 0) return 1'b0;
    if (k == 9) return 1'b1;
    return b[k-1];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive_frame(input bit on_pad, input logic [7:0] b, input bit stop);
    for (int k = 0; k < 10; k++) begin
      logic v;
      v = (k == 9) ? stop : frame_bit(b, k);
      if (on_pad) pad_drv = v; else rx_drv = v;
      wait_cyc(BIT);
    end
    pad_drv = 1'b1;
    rx_drv  = 1'b1;
    wait_cyc(BIT);
  endtask

  task automatic recv_check(input bit on_pad, input logic [7:0] b, input string tag);
    int c0;
    c0 = rx_cnt;
    drive_frame(on_pad, b, 1'b1);
    check(rx_cnt == c0 + 1, {tag, " strobe count"}, rx_cnt - c0, 1);
    check(rx_last == b, {tag, " data"}, rx_last, b);
    check(ferr_last == 1'b0, "R6 no frame error", ferr_last, 0);
  endtask

  task automatic send_tx(input logic [7:0] b, input bit half, input int inj);
    int n;
    @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    n = 0;
    while (!tx_ready && n < 12 * BIT) begin @(negedge clk); n++; end
    @(negedge clk);
    tx_valid = 1'b0;
    check(tx_ready == 1'b0, "R3 ready low after accept", tx_ready, 0);
    for (int k = 0; k < 10; k++) begin
      wait_cyc(BIT / 4);
      if (k == inj) pad_drv = 1'b0;
      wait_cyc(BIT / 4);
      check(txd == frame_bit(b, k), "R2 tx bit", txd, frame_bit(b, k));
      if (half) check(txd_oe == 1'b1, "R8 oe during frame", txd_oe, 1);
      wait_cyc(BIT / 4);
      pad_drv = 1'b1;
      wait_cyc(BIT / 4);
    end
    n = 0;
    while (!tx_ready && n < 2 * BIT) begin @(negedge clk); n++; end
    check(tx_ready == 1'b1, "R3 ready after stop", tx_ready, 1);
    check(txd == 1'b1, "R2 idle high", txd, 1);
    if (half) check(txd_oe == 1'b0, "R8 released after frame", txd_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int c0;
    void'($urandom(32'h1F3A_5EED));
    wait_cyc(10);
    rst_n = 1'b1;
    wait_cyc(2);
    check(tx_ready == 1'b1, "R1 ready", tx_ready, 1);
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(txd_oe == 1'b1, "R1 oe", txd_oe, 1);
    check(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    check(cfg_err == 1'b0, "R1 cfg_err", cfg_err, 0);

    send_tx(8'h00, 1'b0, -1);
    send_tx(8'hFF, 1'b0, -1);
    send_tx(8'hA5, 1'b0, -1);
    for (int i = 0; i < 4; i++) send_tx(8'($urandom), 1'b0, -1);

    recv_check(1'b0, 8'h00, "R4");
    recv_check(1'b0, 8'hFF, "R4");
    recv_check(1'b0, 8'h5A, "R4");
    for (int i = 0; i < 4; i++) recv_check(1'b0, 8'($urandom), "R4");

    c0 = rx_cnt;
    drive_frame(1'b0, 8'h3C, 1'b0);
    check(rx_cnt == c0 + 1, "R6 strobe count", rx_cnt - c0, 1);
    check(ferr_last == 1'b1, "R6 frame error", ferr_last, 1);
    check(rx_last == 8'h3C, "R6 data", rx_last, 8'h3C);
    recv_check(1'b0, 8'h81, "R6 recovery");

    c0 = rx_cnt;
    rx_drv = 1'b0;
    wait_cyc(3 * CPT);
    rx_drv = 1'b1;
    wait_cyc(20 * BIT);
    check(rx_cnt == c0, "R5 glitch rejected", rx_cnt - c0, 0);

    half_dup = 1'b1;
    wait_cyc(4);
    check(txd_oe == 1'b0, "R8 idle released", txd_oe, 0);
    c0 = rx_cnt;
    drive_frame(1'b0, 8'h96, 1'b1);
    check(rx_cnt == c0, "R7 rxd ignored", rx_cnt - c0, 0);
    check(txd_oe == 1'b0, "R8 released after rx attempt", txd_oe, 0);
    recv_check(1'b1, 8'hC3, "R7");
    for (int i = 0; i < 3; i++) recv_check(1'b1, 8'($urandom), "R7");

    for (int i = 0; i < 3; i++) begin
      int r0, k0;
      r0 = rx_cnt;
      k0 = col_cnt;
      send_tx(8'($urandom), 1'b1, -1);
      wait_cyc(BIT);
      check(rx_cnt == r0, "R9 no echo", rx_cnt - r0, 0);
      check(col_cnt == k0, "R10 no false collision", col_cnt - k0, 0);
    end
    c0 = col_cnt;
    send_tx(8'hFF, 1'b1, 3);
    wait_cyc(4);
    check(col_cnt == c0 + 1, "R10 collision", col_cnt - c0, 1);

    alt_func = 1'b1;
    wait_cyc(4);
    check(cfg_err == 1'b1, "R11 cfg_err", cfg_err, 1);
    check(txd_oe == 1'b1, "R11 oe held", txd_oe, 1);
    recv_check(1'b0, 8'h4E, "R11");
    send_tx(8'h72, 1'b0, -1);
    check(txd_oe == 1'b1, "R11 oe after tx", txd_oe, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule